// File: doc/BRIEF.md
# Mode-Banked General Register File

This block is the general register storage for a 32-bit processor core. It holds sixteen general registers, reached by a 4-bit index. The lower eight indices exist twice, as bank 0 and bank 1. The upper eight are single registers that every mode and bank sees. The core supplies a privilege bit and a bank-select bit. Together they decide which physical copy of indices 0–7 the general ports reach. The block has two combinational read ports, one write port that commits on the clock edge, and a dedicated output that always carries the mapped register 0 for indexed addressing.

Privileged software has two extra paths. The alternate-bank port reads and writes the copy of registers 0–7 that the general ports currently cannot see. The control-register port reaches three privileged registers: saved status, vector base and saved program counter. When either path is requested in user mode, the block refuses it. It raises a fault flag in that same cycle, returns zero and leaves all storage as it was.

Top module: `banked_regfile`

## Requirements
- R1: Reset clears both banks, the shared registers and the three control registers to zero.
- R2: Indices 8 to 15 reach the same physical register in every combination of mode and bank select.
- R3: In user mode (privMode = 0), indices 0 to 7 map to bank 0, whatever value bankSel has.
- R4: In privileged mode (privMode = 1), indices 0 to 7 map to bank 1 when bankSel = 1 and to bank 0 when bankSel = 0.
- R5: A write through the general port changes only the mapped physical copy. The copy of the same index in the other bank keeps its value.
- R6: In privileged mode, the alternate-bank port (altEn = 1, 3-bit altIdx) reads the unmapped bank combinationally. With altWrite = 1 it writes that bank on the clock edge.
- R7: In privileged mode, the control port (ctlEn = 1) selects a register by ctlSel: 0 = saved status, 1 = vector base, 2 = saved program counter. Code 3 reads zero and ignores writes. With ctlWrite = 1 the selected register is written on the clock edge.
- R8: In user mode, a request on the alternate-bank or control port sets fault = 1 in that cycle. The request returns zero on altRdData and ctlRdData and changes no storage. fault = 0 in every other case.
- R9: Both general read ports are combinational. A write commits at the clock edge, so a read of the address being written in the same cycle returns the old value.
- R10: idxReg0 always carries register 0 of the currently mapped bank.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous active-low reset |
| privMode | input | 1 | 1 = privileged mode, 0 = user mode |
| bankSel | input | 1 | Bank select for indices 0–7; has effect only in privileged mode |
| rdAddrA | input | 4 | Read port A index |
| rdDataA | output | 32 | Read port A data |
| rdAddrB | input | 4 | Read port B index |
| rdDataB | output | 32 | Read port B data |
| wrEn | input | 1 | General write enable |
| wrAddr | input | 4 | General write index |
| wrData | input | 32 | General write data |
| altEn | input | 1 | Alternate-bank access request |
| altWrite | input | 1 | Alternate-bank access is a write |
| altIdx | input | 3 | Register index within the hidden bank |
| altWrData | input | 32 | Alternate-bank write data |
| altRdData | output | 32 | Alternate-bank read data |
| ctlEn | input | 1 | Control-register access request |
| ctlWrite | input | 1 | Control-register access is a write |
| ctlSel | input | 2 | Control-register select |
| ctlWrData | input | 32 | Control-register write data |
| ctlRdData | output | 32 | Control-register read data |
| idxReg0 | output | 32 | Mapped register 0 for indexed addressing |
| fault | output | 1 | Privileged access refused in this cycle |

## Verification
If the bank mapping is wrong, the fault shows on the read ports in the very cycle the mode or bank bit changes. A register that the other mode wrote earlier comes back on rdDataA, rdDataB or idxReg0. A write that lands in the wrong copy stays hidden until that copy is mapped in or read through the alternate port. For that reason, the bench keeps a full shadow of both banks and compares every port on every cycle. A refused access that still commits only shows up later, when a privileged read reaches the register it corrupted.

// File: rtl/brf_pkg.sv
package brf_pkg;

  // strobes from control to datapath
  typedef struct packed {
    logic activeBank;  // physical bank mapped to indices 0..7
    logic genWe;       // general port write
    logic altRd;       // alternate-bank read allowed
    logic altWe;       // alternate-bank write allowed
    logic ctlRd;       // control register read allowed
    logic ctlWe;       // control register write allowed
  } brf_stb_t;

  typedef enum logic [1:0] {
    CTL_SAVED_STAT = 2'd0,
    CTL_VEC_BASE   = 2'd1,
    CTL_SAVED_PC   = 2'd2,
    CTL_UNUSED     = 2'd3
  } brf_ctl_e;

  localparam int NUM_CTL = 3;

endpackage

// File: rtl/brf_ctrl.sv
module brf_ctrl
  import brf_pkg::*;
(
  input  logic     clk,
  input  logic     rstN,
  input  logic     privMode,
  input  logic     bankSel,
  input  logic     wrEn,
  input  logic     altEn,
  input  logic     altWrite,
  input  logic     ctlEn,
  input  logic     ctlWrite,
  output brf_stb_t stb,
  output logic     fault
);

  logic refused;

  always_comb begin
    refused        = !privMode && (altEn || ctlEn);
    stb.activeBank = privMode && bankSel;   // user mode forces bank 0
    stb.genWe      = wrEn;
    stb.altRd      = altEn && privMode;
    stb.altWe      = altEn && altWrite && privMode;
    stb.ctlRd      = ctlEn && privMode;
    stb.ctlWe      = ctlEn && ctlWrite && privMode;
    fault          = refused;
  end

  // R8
  refused_no_write_chk: assert property (@(posedge clk) disable iff (!rstN)
    fault |-> (!stb.altWe && !stb.ctlWe && !stb.altRd && !stb.ctlRd));

endmodule

// File: rtl/brf_datapath.sv
module brf_datapath
  import brf_pkg::*;
#(
  parameter int DATA_W     = 32,
  parameter int NUM_BANKED = 8,
  parameter int NUM_SHARED = 8,
  localparam int ADDR_W    = $clog2(NUM_BANKED + NUM_SHARED),
  localparam int BIDX_W    = $clog2(NUM_BANKED),
  localparam int SIDX_W    = $clog2(NUM_SHARED)
) (
  input  logic              clk,
  input  logic              rstN,
  input  brf_stb_t          stb,
  input  logic [ADDR_W-1:0] rdAddrA,
  output logic [DATA_W-1:0] rdDataA,
  input  logic [ADDR_W-1:0] rdAddrB,
  output logic [DATA_W-1:0] rdDataB,
  input  logic [ADDR_W-1:0] wrAddr,
  input  logic [DATA_W-1:0] wrData,
  input  logic [BIDX_W-1:0] altIdx,
  input  logic [DATA_W-1:0] altWrData,
  output logic [DATA_W-1:0] altRdData,
  input  logic [1:0]        ctlSel,
  input  logic [DATA_W-1:0] ctlWrData,
  output logic [DATA_W-1:0] ctlRdData,
  output logic [DATA_W-1:0] idxReg0
);

  logic [DATA_W-1:0] bankMem   [2][NUM_BANKED];
  logic [DATA_W-1:0] sharedMem [NUM_SHARED];
  logic [DATA_W-1:0] ctlQ      [NUM_CTL];

  logic                wrIsBanked;
  logic [ADDR_W-1:0]   wrOff;
  logic                hiddenBank;

  function automatic logic [DATA_W-1:0] genRead(input logic [ADDR_W-1:0] addr,
                                               input logic bank);
    logic [ADDR_W-1:0] off;
    off = addr - ADDR_W'(NUM_BANKED);
    if (addr < ADDR_W'(NUM_BANKED))
      return bankMem[bank][addr[BIDX_W-1:0]];
    else
      return sharedMem[off[SIDX_W-1:0]];
  endfunction

  always_comb begin
    wrIsBanked = wrAddr < ADDR_W'(NUM_BANKED);
    wrOff      = wrAddr - ADDR_W'(NUM_BANKED);
    hiddenBank = !stb.activeBank;
  end

  // banked and shared storage
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      for (int b = 0; b < 2; b++)
        for (int i = 0; i < NUM_BANKED; i++)
          bankMem[b][i] <= '0;
      for (int i = 0; i < NUM_SHARED; i++)
        sharedMem[i] <= '0;
    end else begin
      if (stb.genWe && wrIsBanked)
        bankMem[stb.activeBank][wrAddr[BIDX_W-1:0]] <= wrData;
      if (stb.genWe && !wrIsBanked)
        sharedMem[wrOff[SIDX_W-1:0]] <= wrData;
      if (stb.altWe)
        bankMem[hiddenBank][altIdx] <= altWrData;
    end
  end

  // privileged control registers, one per code
  for (genvar k = 0; k < NUM_CTL; k++) begin : g_ctl
    logic [DATA_W-1:0] q;
    always_ff @(posedge clk or negedge rstN) begin
      if (!rstN)
        q <= '0;
      else if (stb.ctlWe && ctlSel == 2'(k))
        q <= ctlWrData;
    end
    assign ctlQ[k] = q;
  end

  always_comb begin
    rdDataA   = genRead(rdAddrA, stb.activeBank);
    rdDataB   = genRead(rdAddrB, stb.activeBank);
    idxReg0   = bankMem[stb.activeBank][0];
    altRdData = stb.altRd ? bankMem[hiddenBank][altIdx] : '0;
    ctlRdData = '0;
    if (stb.ctlRd && ctlSel != CTL_UNUSED)
      ctlRdData = ctlQ[ctlSel];
  end

  // R5
  other_bank_kept_chk: assert property (@(posedge clk) disable iff (!rstN)
    (stb.genWe && wrIsBanked && !(stb.altWe && altIdx == wrAddr[BIDX_W-1:0]))
    |=> bankMem[$past(hiddenBank)][$past(wrAddr[BIDX_W-1:0])]
        == $past(bankMem[hiddenBank][wrAddr[BIDX_W-1:0]]));

  // R9
  write_visible_next_chk: assert property (@(posedge clk) disable iff (!rstN)
    (stb.genWe && wrAddr == rdAddrA) ##1 ($stable(rdAddrA) && $stable(stb.activeBank))
    |-> rdDataA == $past(wrData));

  // R8
  ctl_hold_chk: assert property (@(posedge clk) disable iff (!rstN)
    !stb.ctlWe |=> (ctlQ[0] == $past(ctlQ[0]) && ctlQ[1] == $past(ctlQ[1])
                    && ctlQ[2] == $past(ctlQ[2])));

endmodule

// File: rtl/banked_regfile.sv
module banked_regfile
  import brf_pkg::*;
#(
  parameter int DATA_W     = 32,
  parameter int NUM_BANKED = 8,
  parameter int NUM_SHARED = 8,
  localparam int ADDR_W    = $clog2(NUM_BANKED + NUM_SHARED),
  localparam int BIDX_W    = $clog2(NUM_BANKED)
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              privMode,
  input  logic              bankSel,
  input  logic [ADDR_W-1:0] rdAddrA,
  output logic [DATA_W-1:0] rdDataA,
  input  logic [ADDR_W-1:0] rdAddrB,
  output logic [DATA_W-1:0] rdDataB,
  input  logic              wrEn,
  input  logic [ADDR_W-1:0] wrAddr,
  input  logic [DATA_W-1:0] wrData,
  input  logic              altEn,
  input  logic              altWrite,
  input  logic [BIDX_W-1:0] altIdx,
  input  logic [DATA_W-1:0] altWrData,
  output logic [DATA_W-1:0] altRdData,
  input  logic              ctlEn,
  input  logic              ctlWrite,
  input  logic [1:0]        ctlSel,
  input  logic [DATA_W-1:0] ctlWrData,
  output logic [DATA_W-1:0] ctlRdData,
  output logic [DATA_W-1:0] idxReg0,
  output logic              fault
);

  brf_stb_t stb;

  brf_ctrl u_ctrl (
    .clk      (clk),
    .rstN     (rstN),
    .privMode (privMode),
    .bankSel  (bankSel),
    .wrEn     (wrEn),
    .altEn    (altEn),
    .altWrite (altWrite),
    .ctlEn    (ctlEn),
    .ctlWrite (ctlWrite),
    .stb      (stb),
    .fault    (fault)
  );

  brf_datapath #(
    .DATA_W     (DATA_W),
    .NUM_BANKED (NUM_BANKED),
    .NUM_SHARED (NUM_SHARED)
  ) u_dp (
    .clk       (clk),
    .rstN      (rstN),
    .stb       (stb),
    .rdAddrA   (rdAddrA),
    .rdDataA   (rdDataA),
    .rdAddrB   (rdAddrB),
    .rdDataB   (rdDataB),
    .wrAddr    (wrAddr),
    .wrData    (wrData),
    .altIdx    (altIdx),
    .altWrData (altWrData),
    .altRdData (altRdData),
    .ctlSel    (ctlSel),
    .ctlWrData (ctlWrData),
    .ctlRdData (ctlRdData),
    .idxReg0   (idxReg0)
  );

  // R3
  user_bank0_chk: assert property (@(posedge clk) disable iff (!rstN)
    !privMode |-> !stb.activeBank);

  // R8
  refused_reads_zero_chk: assert property (@(posedge clk) disable iff (!rstN)
    fault |-> (altRdData == '0 && ctlRdData == '0));

endmodule

// File: tb/banked_regfile_tb.sv
module banked_regfile_tb;

  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        privMode = 1'b0, bankSel = 1'b0;
  logic [3:0]  rdAddrA = '0, rdAddrB = '0, wrAddr = '0;
  logic [31:0] rdDataA, rdDataB, wrData = '0;
  logic        wrEn = 1'b0, altEn = 1'b0, altWrite = 1'b0;
  logic [2:0]  altIdx = '0;
  logic [31:0] altWrData = '0, altRdData;
  logic        ctlEn = 1'b0, ctlWrite = 1'b0;
  logic [1:0]  ctlSel = '0;
  logic [31:0] ctlWrData = '0, ctlRdData, idxReg0;
  logic        fault;

  int compared = 0;
  int mismatched = 0;
  string phase = "";
  logic done = 1'b0;

  logic [31:0] refBank [2][8];
  logic [31:0] refShared [8];
  logic [31:0] refCtl [3];

  always #5 clk = ~clk;

  banked_regfile u_dut (
    .clk(clk), .rstN(rstN), .privMode(privMode), .bankSel(bankSel),
    .rdAddrA(rdAddrA), .rdDataA(rdDataA), .rdAddrB(rdAddrB), .rdDataB(rdDataB),
    .wrEn(wrEn), .wrAddr(wrAddr), .wrData(wrData),
    .altEn(altEn), .altWrite(altWrite), .altIdx(altIdx), .altWrData(altWrData),
    .altRdData(altRdData), .ctlEn(ctlEn), .ctlWrite(ctlWrite), .ctlSel(ctlSel),
    .ctlWrData(ctlWrData), .ctlRdData(ctlRdData), .idxReg0(idxReg0), .fault(fault)
  );

  function automatic logic actBank();
    return privMode && bankSel;
  endfunction

  function automatic logic [31:0] expGen(input logic [3:0] a);
    if (a < 4'd8) return refBank[actBank()][a[2:0]];
    return refShared[a[2:0]];
  endfunction

  function automatic string genTag(input logic [3:0] a);
    if (a >= 4'd8) return "R2";
    if (!privMode) return "R3";
    return "R4";
  endfunction

  function automatic logic [31:0] expAlt();
    if (privMode && altEn) return refBank[!actBank()][altIdx];
    return '0;
  endfunction

  function automatic logic [31:0] expCtl();
    if (privMode && ctlEn && ctlSel != 2'd3) return refCtl[ctlSel];
    return '0;
  endfunction

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    compared++;
    if (act !== exp) begin
      mismatched++;
      $display("FAIL %s %s actual=%h expected=%h at %0t", phase, tag, act, exp, $time);
    end
  endtask

  task automatic checkAll();
    chk({genTag(rdAddrA), " R9 rdDataA"}, rdDataA, expGen(rdAddrA));
    chk({genTag(rdAddrB), " R9 rdDataB"}, rdDataB, expGen(rdAddrB));
    chk("R10 idxReg0", idxReg0, expGen(4'd0));
    chk("R6 altRdData", altRdData, expAlt());
    chk("R7 ctlRdData", ctlRdData, expCtl());
    chk("R8 fault", {31'd0, fault}, {31'd0, !privMode && (altEn || ctlEn)});
  endtask

  // inputs are already set (after a negedge); check, clock, update model
  task automatic step();
    #2;
    checkAll();
    @(posedge clk);
    if (wrEn) begin
      if (wrAddr < 4'd8) refBank[actBank()][wrAddr[2:0]] = wrData;
      else refShared[wrAddr[2:0]] = wrData;
    end
    if (privMode && altEn && altWrite) refBank[!actBank()][altIdx] = altWrData;
    if (privMode && ctlEn && ctlWrite && ctlSel != 2'd3) refCtl[ctlSel] = ctlWrData;
    @(negedge clk);
  endtask

  task automatic idle();
    wrEn = 0; altEn = 0; altWrite = 0; ctlEn = 0; ctlWrite = 0;
  endtask

  initial begin
    #1500000;
    if (!done) begin
      mismatched++;
      compared++;
      $display("FAIL watchdog expired");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
      $finish;
    end
  end

  initial begin
    int seedDummy;
    seedDummy = $urandom(32'd2024);
    for (int b = 0; b < 2; b++) for (int i = 0; i < 8; i++) refBank[b][i] = '0;
    for (int i = 0; i < 8; i++) refShared[i] = '0;
    for (int i = 0; i < 3; i++) refCtl[i] = '0;

    repeat (3) @(negedge clk);
    rstN = 1'b1;

    // R1: everything reads zero after reset, both banks via general and alternate port
    phase = "R1";
    for (int s = 0; s < 2; s++) begin
      for (int a = 0; a < 16; a += 2) begin
        idle();
        privMode = 1; bankSel = s[0];
        rdAddrA = 4'(a); rdAddrB = 4'(a + 1);
        altEn = 1; altIdx = 3'(a / 2);
        ctlEn = 1; ctlSel = 2'(a % 4);
        step();
      end
    end

    // R5: write in each mode/bank combination, then view both copies
    phase = "R5";
    for (int c = 0; c < 4; c++) begin
      idle();
      privMode = c[1]; bankSel = c[0];
      wrEn = 1; wrAddr = 4'd5; wrData = 32'hA5A50000 + 32'(c);
      rdAddrA = 4'd5; rdAddrB = 4'd13;
      step();
      for (int v = 0; v < 2; v++) begin
        idle();
        privMode = 1; bankSel = v[0];
        rdAddrA = 4'd5; altEn = 1; altIdx = 3'd5;
        step();
      end
    end

    // R9: same-cycle read of the written register returns the old value
    phase = "R9";
    idle();
    privMode = 1; bankSel = 1;
    wrEn = 1; wrAddr = 4'd9; wrData = 32'h1234_5678;
    rdAddrA = 4'd9; rdAddrB = 4'd9;
    step();
    idle();
    step();
    wrEn = 1; wrAddr = 4'd0; wrData = 32'hCAFE_0001; rdAddrA = 4'd0;
    step();
    idle();
    step();

    // R8: refused user-mode accesses change nothing
    phase = "R8";
    idle();
    privMode = 1; ctlEn = 1; ctlWrite = 1; ctlSel = 2'd1; ctlWrData = 32'h0000_BEEF;
    step();
    idle();
    privMode = 0; bankSel = 1;
    ctlEn = 1; ctlWrite = 1; ctlSel = 2'd1; ctlWrData = 32'hDEAD_DEAD;
    altEn = 1; altWrite = 1; altIdx = 3'd5; altWrData = 32'hDEAD_0005;
    step();
    idle();
    privMode = 1; bankSel = 0;
    ctlEn = 1; ctlSel = 2'd1; altEn = 1; altIdx = 3'd5;
    step();
    ctlSel = 2'd3; ctlWrite = 1; ctlWrData = 32'hFFFF_FFFF;
    phase = "R7";
    step();
    ctlWrite = 0;
    step();

    // random traffic
    phase = "RND";
    for (int n = 0; n < 4000; n++) begin
      privMode  = ($urandom % 4) != 0;
      bankSel   = 1'($urandom);
      rdAddrA   = 4'($urandom);
      rdAddrB   = 4'($urandom);
      wrEn      = ($urandom % 3) == 0;
      wrAddr    = 4'($urandom);
      wrData    = $urandom;
      altEn     = ($urandom % 3) == 0;
      altWrite  = 1'($urandom);
      altIdx    = 3'($urandom);
      altWrData = $urandom;
      ctlEn     = ($urandom % 4) == 0;
      ctlWrite  = 1'($urandom);
      ctlSel    = 2'($urandom);
      ctlWrData = $urandom;
      step();
    end

    done = 1'b1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
    $finish;
  end

endmodule